// File: doc/BRIEF.md
# Button-Stepped Four-Rate LED Blinker

This block drives a single LED line that flips level at one of four rates. A raw push-button input steps the active rate through a fixed ring of four. Every part runs on the one system clock. Four free-running counters each emit a one-cycle enable at their own rate. A four-way selector picks one of those enables, and a toggle flop inverts the LED whenever the picked enable fires.

The button is first passed through a two-flop synchronizer. A debounce state machine then filters it. The machine has four states:
- `DB_LOW`: the settled low level.
- `DB_RISING`: a high level that is still being timed.
- `DB_HIGH`: the settled high level.
- `DB_FALLING`: a low level that is still being timed.

The transitions are:
- `DB_LOW`→`DB_RISING` when a high sample is seen.
- `DB_RISING`→`DB_LOW` when the input drops early.
- `DB_RISING`→`DB_HIGH` when the high level has lasted the full window. This transition emits the press event.
- `DB_HIGH`→`DB_FALLING` when a low sample is seen.
- `DB_FALLING`→`DB_HIGH` when the input rises early.
- `DB_FALLING`→`DB_LOW` when the low level has lasted the full window.

Each press event advances a two-bit index, which wraps from 3 back to 0.

Top module: `rate_blinker`

## Requirements
- R1: Index values 0, 1, 2 and 3 select LED toggle intervals of CLK_HZ, CLK_HZ/2, CLK_HZ/5 and CLK_HZ/10 clock cycles (1, 2, 5 and 10 toggles per second).
- R2: Each rate source gives a single-cycle enable. After reset is released, its first enable falls in the cycle that completes its P-th clock edge, where P is that source's interval. A source never gives enables on two consecutive cycles.
- R3: The LED inverts on the clock edge where the selected enable is high, and keeps its level on every other edge.
- R4: While `rst` is sampled high at a clock edge, the LED is forced to 0.
- R5: Reset clears the rate index to 0, which is the slowest rate. This clear is asynchronous.
- R6: A change of the button level that lasts fewer than DEBOUNCE_CYCLES cycles is ignored and does not move the rate index.
- R7: The index advances by exactly one per accepted press, on the debounced rising edge. Holding the button down does not advance it again.
- R8: Advancing from index 3 gives index 0.
- R9: A change of index leaves the LED level and all rate counters untouched. The next toggle comes on the next enable of the newly selected source, so every toggle lies on a multiple of the active interval counted from reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst | input | 1 | Active-high reset |
| btn_raw | input | 1 | Unsynchronized push-button level, high when pressed |
| led_o | output | 1 | LED drive |

## Verification
The properties assume that reset is held for at least one clock edge. They also assume that every rate interval is at least two cycles, so an enable cannot repeat on back-to-back cycles; the bench meets this by building with CLK_HZ = 100, which gives intervals of 100, 50, 20 and 10 cycles. Button activity is either a glitch much shorter than the debounce window or a press held and released well past it. This way each intended press yields exactly one event, and no press lands in the same cycle as reset.

// File: rtl/blink_pkg.sv
package blink_pkg;

    localparam int unsigned NUM_RATES = 4;
    localparam int unsigned IDX_W     = $clog2(NUM_RATES);

    typedef enum logic [1:0] {
        DB_LOW,
        DB_RISING,
        DB_HIGH,
        DB_FALLING
    } db_state_t;

    // Toggle rate in hertz for each selector slot
    function automatic int unsigned rate_hz(input int unsigned idx);
        case (idx)
            0:       return 1;
            1:       return 2;
            2:       return 5;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/rate_tick_gen.sv
module rate_tick_gen #(
    parameter int unsigned PERIOD = 10
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] TERM = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == TERM) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == TERM);

endmodule

// File: rtl/btn_debounce.sv
module btn_debounce
    import blink_pkg::*;
#(
    parameter int unsigned STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic press_o,
    output logic level_o
);
    localparam int unsigned CW = (STABLE_CYCLES > 2) ? $clog2(STABLE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    logic      sync1_q, sync2_q;
    db_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= btn_raw;
            sync2_q <= sync1_q;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DB_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        unique case (state_q)
            DB_LOW: begin
                cnt_d = '0;
                if (sync2_q) state_d = DB_RISING;
            end
            DB_RISING: begin
                if (!sync2_q) begin
                    state_d = DB_LOW;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = DB_HIGH;
                    cnt_d   = '0;
                end
            end
            DB_HIGH: begin
                cnt_d = '0;
                if (!sync2_q) state_d = DB_FALLING;
            end
            DB_FALLING: begin
                if (sync2_q) begin
                    state_d = DB_HIGH;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = DB_LOW;
                    cnt_d   = '0;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        press_o = 1'b0;
        level_o = 1'b0;
        unique case (state_q)
            DB_LOW:     level_o = 1'b0;
            DB_RISING:  press_o = sync2_q && (cnt_q == LAST);
            DB_HIGH:    level_o = 1'b1;
            DB_FALLING: level_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/rate_index.sv
module rate_index
    import blink_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    output logic [IDX_W-1:0] idx_o
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            idx_o <= '0;
        end else if (step_i) begin
            idx_o <= idx_o + 1'b1;
        end
    end

endmodule

// File: rtl/rate_blinker.sv
module rate_blinker
    import blink_pkg::*;
#(
    parameter int unsigned CLK_HZ          = 100_000_000,
    parameter int unsigned DEBOUNCE_CYCLES = CLK_HZ / 100
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic led_o
);
    logic [NUM_RATES-1:0] tick_vec;
    logic [IDX_W-1:0]     sel_idx;
    logic                 press_evt;
    logic                 btn_level;
    logic                 sel_tick;

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        rate_tick_gen #(
            .PERIOD(CLK_HZ / rate_hz(g))
        ) u_tick (
            .clk   (clk),
            .rst   (rst),
            .tick_o(tick_vec[g])
        );
    end

    btn_debounce #(
        .STABLE_CYCLES(DEBOUNCE_CYCLES)
    ) u_debounce (
        .clk    (clk),
        .rst    (rst),
        .btn_raw(btn_raw),
        .press_o(press_evt),
        .level_o(btn_level)
    );

    rate_index u_index (
        .clk   (clk),
        .rst   (rst),
        .step_i(press_evt),
        .idx_o (sel_idx)
    );

    assign sel_tick = tick_vec[sel_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            led_o <= 1'b0;
        end else if (sel_tick) begin
            led_o <= ~led_o;
        end
    end

endmodule

// File: rtl/rate_blinker_checker.sv
module rate_blinker_checker (
    input logic       clk,
    input logic       rst,
    input logic       led,
    input logic [1:0] sel,
    input logic [3:0] tick_vec,
    input logic       press,
    input logic       sel_tick
);
    assert_led_reset_R4: assert property (@(posedge clk) rst |=> !led);

    assert_led_toggle_R3: assert property (@(posedge clk) disable iff (rst)
        sel_tick |=> led != $past(led));

    assert_led_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !sel_tick |=> led == $past(led));

    assert_tick_single_R2: assert property (@(posedge clk) disable iff (rst)
        |tick_vec |=> ((tick_vec & $past(tick_vec)) == 4'b0000));

    assert_index_step_R7: assert property (@(posedge clk) disable iff (rst)
        press |=> sel == $past(sel) + 2'd1);

    assert_index_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !press |=> $stable(sel));

    assert_press_single_R7: assert property (@(posedge clk) disable iff (rst)
        press |=> !press);

    assert_index_reset_R5: assert property (@(posedge clk)
        rst |-> sel == 2'd0);

endmodule

bind rate_blinker rate_blinker_checker chk_i (
    .clk     (clk),
    .rst     (rst),
    .led     (led_o),
    .sel     (sel_idx),
    .tick_vec(tick_vec),
    .press   (press_evt),
    .sel_tick(sel_tick)
);

// File: tb/rate_blinker_tb_top.sv
module rate_blinker_tb_top;

    localparam int unsigned CLK_HZ = 100;
    localparam int unsigned DEB    = 4;
    localparam int unsigned NVEC   = 6;
    // presses before each measurement, expected toggle interval (R1, R8)
    localparam int unsigned PRESSES [NVEC] = '{0, 1, 1, 1, 1, 2};
    localparam int unsigned EXP_GAP [NVEC] = '{100, 50, 20, 10, 100, 20};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_raw = 1'b0;
    logic led_o;
    int unsigned cyc = 0;
    int unsigned wd = 0;
    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rate_blinker #(.CLK_HZ(CLK_HZ), .DEBOUNCE_CYCLES(DEB)) dut_i (
        .clk(clk), .rst(rst), .btn_raw(btn_raw), .led_o(led_o)
    );

    always_ff @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        wd <= wd + 1;
        if (wd > 150000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", wd);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input string req, input int unsigned act, input int unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_toggle(output int unsigned gap);
        int unsigned n = 0;
        logic prev = led_o;
        do begin
            @(negedge clk);
            n++;
        end while (led_o == prev && n < 1000);
        gap = n;
    endtask

    // Syncs to a toggle, checks its phase (R9), then times the next interval
    task automatic measure(input string req, input int unsigned exp);
        int unsigned g;
        wait_toggle(g);
        check({req, "/R9 phase"}, cyc % exp, 0);
        wait_toggle(g);
        check({req, " interval"}, g, exp);
    endtask

    task automatic press(input int unsigned hold);
        btn_raw = 1'b1;
        repeat (hold) @(negedge clk);
        btn_raw = 1'b0;
        repeat (3 * DEB) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R4 led in reset", led_o, 0);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R2 first enable of the slowest source after reset release
        repeat (99) @(negedge clk);
        check("R2 before first tick", led_o, 0);
        @(negedge clk);
        check("R2 first tick", led_o, 1);

        // Table walk: R1 rates, R7 single steps, R8 wrap
        for (int i = 0; i < NVEC; i++) begin
            for (int p = 0; p < PRESSES[i]; p++) press(3 * DEB);
            measure("R1/R8 table", EXP_GAP[i]);
        end

        // R6 short glitches do not advance index (still 2 -> 20)
        for (int k = 0; k < 6; k++) begin
            btn_raw = 1'b1;
            repeat (2) @(negedge clk);
            btn_raw = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (3 * DEB) @(negedge clk);
        measure("R6 bounce", 20);

        // R7 long hold advances only once (2 -> 3)
        press(400);
        measure("R7 hold", 10);

        // R5 reset returns to slowest rate
        do_reset();
        measure("R5 after reset", 100);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule